// File: doc/BRIEF.md
# Banked Low-Activity Word Memory

This block is a 4096-word by 4-bit memory made from four smaller banks of 1024 words each. A single 12-bit address goes to the block. Its top two bits choose one bank and its lower ten bits choose a word inside that bank. The aim is to cut switching activity: only the bank being addressed gets a clock enable. The user read and write enables are combined with the bank decode. They are not tied on, so a cycle with no request touches no storage at all.

Reads and writes use one common clock. A read returns data one cycle after the request. The bank choice is registered together with the read, so the output multiplexer forwards data from the bank that actually produced it. When no read is requested, the read output keeps its last value.

The per-bank read and write enables are brought out as ports. Surrounding logic and checks can use them to confirm that at most one bank is active in any cycle.

Top module: `banked_ram`

## Requirements
- R1: Each of the 4096 addresses stores its own 4-bit value. A write followed later by a read of the same address returns that value.
- R2: Address bits [11:10] select the bank and bits [9:0] select the word in it. Addresses that share bits [9:0] but differ in bits [11:10] never overwrite each other.
- R3: `bank_rd_ce` is all zero when `rd_en` is low. When `rd_en` is high it has exactly one bit set, at index addr[11:10].
- R4: `bank_wr_ce` is all zero when `wr_en` is low. When `wr_en` is high it has exactly one bit set, at index addr[11:10].
- R5: In every cycle, the OR of `bank_rd_ce` and `bank_wr_ce` has at most one bit set.
- R6: Read data for a request sampled at a rising edge appears on `rdata` right after that edge, with one cycle of latency. It is taken from the bank addressed in that request.
- R7: While `rd_en` is low, including cycles that write, `rdata` does not change.
- R8: A cycle with both enables low sets no bank enable and changes no stored word, whatever the address and write data.
- R9: A synchronous active-high `rst` sets `rdata` to zero and the registered bank choice to bank 0. Stored words survive the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for both ports |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read request |
| wr_en | input | 1 | Write request |
| addr | input | 12 | Word address; top two bits pick the bank |
| wdata | input | 4 | Write data |
| rdata | output | 4 | Registered read data |
| bank_rd_ce | output | 4 | Per-bank read clock enable |
| bank_wr_ce | output | 4 | Per-bank write clock enable |

## Verification
The memory is first filled and then read across all 4096 addresses in order, so every bank and every word is covered and a wrong decode shows up as a mismatch. One word offset is then written in all four banks with different values and read back, which separates the bank-select bits from the word bits. Idle cycles with arbitrary address and data are followed by readback, to show that nothing was written, and writes with reads off show that the output holds. The run ends with a mid-run reset and a long random mix of reads, writes and idle cycles. The mix never reads and writes in the same cycle, since that result is left open.

// File: rtl/banked_ram_pkg.sv
package banked_ram_pkg;
  parameter int unsigned RAM_ADDR_W = 12;
  parameter int unsigned RAM_DATA_W = 4;
  parameter int unsigned RAM_SEL_W  = 2;
endpackage

// File: rtl/bank_decoder.sv
module bank_decoder #(
  parameter int unsigned SEL_W = 2,
  parameter int unsigned NB    = 4
) (
  input  logic [SEL_W-1:0] sel,
  input  logic             rd_en,
  input  logic             wr_en,
  output logic [NB-1:0]    rd_ce,
  output logic [NB-1:0]    wr_ce
);
  logic [NB-1:0] hit;

  for (genvar g = 0; g < NB; g++) begin : g_dec
    assign hit[g]   = (sel == SEL_W'(g));
    assign rd_ce[g] = rd_en & hit[g];
    assign wr_ce[g] = wr_en & hit[g];
  end
endmodule

// File: rtl/ram_bank.sv
module ram_bank #(
  parameter int unsigned AW = 10,
  parameter int unsigned DW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_ce,
  input  logic          wr_ce,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_ce) store[addr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (rd_ce) q <= store[addr];
  end

  // R7
  bank_q_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_ce |=> $stable(q));
endmodule

// File: rtl/banked_ram.sv
module banked_ram
  import banked_ram_pkg::*;
#(
  parameter int unsigned ADDR_W = RAM_ADDR_W,
  parameter int unsigned DATA_W = RAM_DATA_W,
  parameter int unsigned SEL_W  = RAM_SEL_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   rd_en,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [DATA_W-1:0]      wdata,
  output logic [DATA_W-1:0]      rdata,
  output logic [(1<<SEL_W)-1:0]  bank_rd_ce,
  output logic [(1<<SEL_W)-1:0]  bank_wr_ce
);
  localparam int unsigned NB      = 1 << SEL_W;
  localparam int unsigned BANK_AW = ADDR_W - SEL_W;

  logic [SEL_W-1:0]   sel;
  logic [SEL_W-1:0]   sel_q;
  logic [BANK_AW-1:0] word;
  logic [DATA_W-1:0]  bank_q [NB];
  logic [NB-1:0]      bank_any;

  assign sel  = addr[ADDR_W-1 -: SEL_W];
  assign word = addr[BANK_AW-1:0];

  bank_decoder #(.SEL_W(SEL_W), .NB(NB)) i_dec (
    .sel   (sel),
    .rd_en (rd_en),
    .wr_en (wr_en),
    .rd_ce (bank_rd_ce),
    .wr_ce (bank_wr_ce)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bank
    ram_bank #(.AW(BANK_AW), .DW(DATA_W)) i_bank (
      .clk   (clk),
      .rst   (rst),
      .rd_ce (bank_rd_ce[b]),
      .wr_ce (bank_wr_ce[b]),
      .addr  (word),
      .wdata (wdata),
      .q     (bank_q[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)        sel_q <= '0;
    else if (rd_en) sel_q <= sel;
  end

  assign rdata    = bank_q[sel_q];
  assign bank_any = bank_rd_ce | bank_wr_ce;

  // R5
  single_bank_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bank_any));

  // R3
  rd_one_bank_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> $countones(bank_rd_ce) == 1);

  // R4
  wr_one_bank_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $countones(bank_wr_ce) == 1);

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!rd_en && !wr_en) |-> (bank_any == '0));

  // R7
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> rdata == '0);
endmodule

// File: tb/test_banked_ram.sv
`timescale 1ns/1ps
module test_banked_ram;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rd_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [11:0] addr = '0;
  logic [3:0] wdata = '0;
  logic [3:0] rdata;
  logic [3:0] bank_rd_ce;
  logic [3:0] bank_wr_ce;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int  mem   [4096];
  bit  known [4096];
  int  exp_q = 0;
  bit  exp_ok = 0;

  always #2.5 clk = ~clk;

  banked_ram i_banked_ram (
    .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .bank_rd_ce(bank_rd_ce), .bank_wr_ce(bank_wr_ce)
  );

  function automatic int pat(int a);
    return (a * 7 + (a >> 10) * 5 + (a >> 3)) & 15;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock: compare last read, drive, check enables, advance model
  task automatic cyc(string tag, bit r, bit w, bit rs, int a, int d);
    int want_rd, want_wr;
    @(negedge clk);
    if (exp_ok) check(tag, rdata, exp_q);
    rst = rs; rd_en = r; wr_en = w; addr = 12'(a); wdata = 4'(d);
    #1;
    want_rd = r ? (1 << (a >> 10)) : 0;
    want_wr = w ? (1 << (a >> 10)) : 0;
    check("R3", bank_rd_ce, want_rd);
    check("R4", bank_wr_ce, want_wr);
    check("R5", ($countones(bank_rd_ce | bank_wr_ce) <= 1) ? 1 : 0, 1);
    @(posedge clk);
    if (rs) begin
      exp_q = 0; exp_ok = 1;
    end else begin
      if (r) begin
        exp_q = mem[a]; exp_ok = known[a];
      end
      if (w) begin
        mem[a] = d; known[a] = 1;
      end
    end
  endtask

  initial begin
    #(200000 * 5.0);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4096; i++) begin mem[i] = 0; known[i] = 0; end
    // R9 reset state
    cyc("R9", 0, 0, 1, 0, 0);
    cyc("R9", 0, 0, 1, 0, 0);
    cyc("R9", 0, 0, 0, 0, 0);
    // R1 fill then read every word
    for (int a = 0; a < 4096; a++) cyc("R1", 0, 1, 0, a, pat(a));
    for (int a = 0; a < 4096; a++) cyc("R6", 1, 0, 0, a, 0);
    cyc("R1", 0, 0, 0, 0, 0);
    // R2 same word offset in each bank
    for (int b = 0; b < 4; b++) cyc("R2", 0, 1, 0, (b << 10) | 12'h155, b + 9);
    for (int b = 3; b >= 0; b--) cyc("R2", 1, 0, 0, (b << 10) | 12'h155, 0);
    cyc("R2", 0, 0, 0, 0, 0);
    // R8 idle with arbitrary address and data, then readback
    for (int i = 0; i < 64; i++) cyc("R8", 0, 0, 0, (i * 263) & 4095, ~pat(i) & 15);
    for (int i = 0; i < 64; i++) cyc("R8", 1, 0, 0, (i * 263) & 4095, 0);
    // R7 writes with read off: output holds
    cyc("R7", 1, 0, 0, 12'hC03, 0);
    for (int i = 0; i < 32; i++) cyc("R7", 0, 1, 0, (i * 129) & 4095, i & 15);
    for (int i = 0; i < 32; i++) cyc("R7", 1, 0, 0, (i * 129) & 4095, 0);
    // R9 reset mid-run, contents kept
    cyc("R9", 1, 0, 0, 12'hFFF, 0);
    cyc("R9", 0, 0, 1, 12'h123, 0);
    cyc("R9", 0, 0, 0, 0, 0);
    for (int a = 0; a < 16; a++) cyc("R9", 1, 0, 0, (a << 8) | a, 0);
    // mixed random traffic
    for (int i = 0; i < 3000; i++) begin
      int k = int'($urandom_range(0, 2));
      int a = int'($urandom_range(0, 4095));
      int d = int'($urandom_range(0, 15));
      cyc("R6", k == 0, k == 1, 0, a, d);
    end
    cyc("R6", 0, 0, 0, 0, 0);
    cyc("R6", 0, 0, 0, 0, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule